// File: doc/BRIEF.md
# Activity-Triggered Power-State Monitor

This block watches the control and data lines of a static memory interface and decides, cycle by cycle, whether the memory should be at full power or in standby. It sees two active-low select inputs, an active-low write strobe, the address bus and the write-data bus. Certain transitions on these lines count as signs of real activity, and each one only counts under its own select and strobe conditions. Any such transition moves the monitor to the active state. A countdown then runs, and when it expires with no further activity the monitor falls back to standby on its own.

Power therefore follows how often accesses arrive, not how long the memory stays selected. A selected memory with stable inputs reaches standby after the hold window. Dropping either select forces standby on the next clock. Edges and changes are found by comparing each input with a registered copy from the previous cycle. Reset loads that copy with idle values: both selects high, the strobe high, address and data zero. A wake event is also reported as a one-cycle pulse that is aligned with the rise or reload of the power flag.

Top module: `apd_monitor`

## Requirements
- R1: While reset is low, and on the first sampled cycle after it, `pwr_active` and `wake_pulse` are 0.
- R2: A 1-to-0 transition on one select that occurs while the other select is low in the same cycle is a wake event. This includes both selects falling together.
- R3: A 1-to-0 transition on `wr_n` while both selects are low is a wake event.
- R4: Any change of `addr` from the previous cycle while both selects are low is a wake event.
- R5: Any change of `wdata` from the previous cycle is a wake event only when both selects and `wr_n` are low.
- R6: Transitions that do not meet the conditions of R2 to R5 do not wake the block. These are: a select falling while the other is high, strobe or address activity while deselected, and data changes with `wr_n` high.
- R7: After the last wake event, `pwr_active` stays 1 for exactly HOLD_CYCLES clock cycles while the selects stay low, then returns to 0.
- R8: A wake event that arrives while active reloads the hold window to its full length.
- R9: A cycle in which either select is high makes `pwr_active` 0 from the next cycle on.
- R10: `wake_pulse` is 1 for exactly the cycle after each wake event, and `pwr_active` never rises without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a_n | input | 1 | First select, active low |
| sel_b_n | input | 1 | Second select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Address bus |
| wdata | input | DATA_W | Write-data bus |
| pwr_active | output | 1 | 1 = full power, 0 = standby |
| wake_pulse | output | 1 | One-cycle flag for a wake event seen in the previous cycle |

## Verification
The bench keeps the default 14-bit address and 4-bit data widths, but builds the block with HOLD_CYCLES set to 5. With that setting, expiry of the hold window, a reload partway through the window, and an exact count of active cycles all fit inside a short vector table. The small window also lets every qualified and unqualified transition be placed both inside an active window and in standby.

// File: rtl/apd_pkg.sv
// Package: shared types for the power-state monitor.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package apd_pkg;

    // Power state held by the hold timer.
    typedef enum logic {
        PWR_STANDBY = 1'b0,
        PWR_ACTIVE  = 1'b1
    } pwr_state_t;

    // Qualified activity flags produced each cycle.
    typedef struct packed {
        logic sel_fall;   // select falling edge with the partner select low
        logic strobe_fall; // write strobe falling edge while selected
        logic addr_chg;   // address change while selected
        logic data_chg;   // write-data change while writing
    } apd_events_t;

    // Registered copy of the interface from the previous cycle.
    typedef struct packed {
        logic sel_a_n;
        logic sel_b_n;
        logic wr_n;
    } apd_ctrl_t;

endpackage

// File: rtl/apd_input_history.sv
// Module: apd_input_history
// Holds the interface inputs as they were one clock earlier.
// Assumes: inputs are synchronous to clk. Reset loads idle values
// (selects and strobe high, buses zero), so the first comparison after
// reset is made against an idle interface.
module apd_input_history
    import apd_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  apd_ctrl_t         ctrl_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output apd_ctrl_t         ctrl_prev,
    output logic [ADDR_W-1:0] addr_prev,
    output logic [DATA_W-1:0] data_prev
);

    localparam apd_ctrl_t CTRL_IDLE = '{sel_a_n: 1'b1, sel_b_n: 1'b1, wr_n: 1'b1};

    // Purpose: capture the control lines each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_prev <= CTRL_IDLE;
        end else begin
            ctrl_prev <= ctrl_in;
        end
    end

    // Purpose: capture the address and write-data buses each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_prev <= '0;
            data_prev <= '0;
        end else begin
            addr_prev <= addr_in;
            data_prev <= data_in;
        end
    end

endmodule

// File: rtl/apd_event_detect.sv
// Module: apd_event_detect
// Compares current inputs against last cycle's copy and qualifies each
// kind of transition with its enable condition. Purely combinational.
// Assumes: prev values come from apd_input_history.
module apd_event_detect
    import apd_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 4
) (
    input  apd_ctrl_t         ctrl_cur,
    input  apd_ctrl_t         ctrl_prev,
    input  logic [ADDR_W-1:0] addr_cur,
    input  logic [ADDR_W-1:0] addr_prev,
    input  logic [DATA_W-1:0] data_cur,
    input  logic [DATA_W-1:0] data_prev,
    output logic              selected,
    output apd_events_t       events,
    output logic              wake
);

    logic [ADDR_W-1:0] addr_bit_chg;
    logic [DATA_W-1:0] data_bit_chg;

    // Per-line change detectors for the address bus.
    for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_addr_bit
        assign addr_bit_chg[gi] = addr_cur[gi] ^ addr_prev[gi];
    end

    // Per-line change detectors for the write-data bus.
    for (genvar gj = 0; gj < DATA_W; gj++) begin : g_data_bit
        assign data_bit_chg[gj] = data_cur[gj] ^ data_prev[gj];
    end

    logic fall_a;
    logic fall_b;
    logic fall_wr;
    logic writing;

    // Purpose: derive edges and qualify each event class.
    always_comb begin
        selected = !ctrl_cur.sel_a_n && !ctrl_cur.sel_b_n;
        writing  = selected && !ctrl_cur.wr_n;
        fall_a   = ctrl_prev.sel_a_n && !ctrl_cur.sel_a_n;
        fall_b   = ctrl_prev.sel_b_n && !ctrl_cur.sel_b_n;
        fall_wr  = ctrl_prev.wr_n && !ctrl_cur.wr_n;

        events.sel_fall    = (fall_a && !ctrl_cur.sel_b_n) || (fall_b && !ctrl_cur.sel_a_n);
        events.strobe_fall = selected && fall_wr;
        events.addr_chg    = selected && (|addr_bit_chg);
        events.data_chg    = writing && (|data_bit_chg);

        wake = |events;
    end

endmodule

// File: rtl/apd_hold_timer.sv
// Module: apd_hold_timer
// Power-state register with a reloadable countdown. A wake loads the full
// window; each quiet selected cycle counts down; deselection clears it.
// Assumes: HOLD_CYCLES >= 1; wake is only asserted while selected.
module apd_hold_timer
    import apd_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic selected,
    input  logic wake,
    output logic pwr_active,
    output logic wake_pulse
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    pwr_state_t       state;
    logic [CNT_W-1:0] remain;

    // Purpose: advance the power state and the hold countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PWR_STANDBY;
            remain <= '0;
        end else if (!selected) begin
            state  <= PWR_STANDBY;
            remain <= '0;
        end else if (wake) begin
            state  <= PWR_ACTIVE;
            remain <= CNT_LOAD;
        end else if (remain > CNT_ONE) begin
            state  <= PWR_ACTIVE;
            remain <= remain - CNT_ONE;
        end else begin
            state  <= PWR_STANDBY;
            remain <= '0;
        end
    end

    // Purpose: register a one-cycle flag for each accepted wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= wake && selected;
        end
    end

    assign pwr_active = (state == PWR_ACTIVE);

endmodule

// File: rtl/apd_monitor.sv
// Module: apd_monitor (top)
// Activity-triggered power-state monitor for a static memory interface.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module apd_monitor
    import apd_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 4,
    parameter int HOLD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              pwr_active,
    output logic              wake_pulse
);

    apd_ctrl_t         ctrl_cur;
    apd_ctrl_t         ctrl_prev;
    logic [ADDR_W-1:0] addr_prev;
    logic [DATA_W-1:0] data_prev;
    logic              selected;
    apd_events_t       events;
    logic              wake;

    // Purpose: bundle the control pins.
    always_comb begin
        ctrl_cur.sel_a_n = sel_a_n;
        ctrl_cur.sel_b_n = sel_b_n;
        ctrl_cur.wr_n    = wr_n;
    end

    apd_input_history #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_in  (ctrl_cur),
        .addr_in  (addr),
        .data_in  (wdata),
        .ctrl_prev(ctrl_prev),
        .addr_prev(addr_prev),
        .data_prev(data_prev)
    );

    apd_event_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_detect (
        .ctrl_cur (ctrl_cur),
        .ctrl_prev(ctrl_prev),
        .addr_cur (addr),
        .addr_prev(addr_prev),
        .data_cur (wdata),
        .data_prev(data_prev),
        .selected (selected),
        .events   (events),
        .wake     (wake)
    );

    apd_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .selected  (selected),
        .wake      (wake),
        .pwr_active(pwr_active),
        .wake_pulse(wake_pulse)
    );

endmodule

// File: rtl/apd_monitor_checker.sv
// Module: apd_monitor_checker
// Port-level properties of apd_monitor, attached by bind.
// Assumes: same parameters as the monitored instance.
module apd_monitor_checker #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_a_n,
    input logic              sel_b_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              pwr_active,
    input logic              wake_pulse
);

    logic primed;

    // Purpose: mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_RESET_STANDBY: assert property (@(posedge clk)
        !rst_n |=> (!pwr_active && !wake_pulse)); // R1

    AST_DESELECT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_n || sel_b_n) |=> !pwr_active); // R9

    AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !sel_a_n && !sel_b_n && addr != $past(addr)) |=> (pwr_active && wake_pulse)); // R4

    AST_STROBE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !sel_a_n && !sel_b_n && $fell(wr_n)) |=> wake_pulse); // R3

    AST_RISE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_active) |-> wake_pulse); // R10

    AST_PULSE_IMPLIES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> pwr_active); // R10

endmodule

bind apd_monitor apd_monitor_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a_n   (sel_a_n),
    .sel_b_n   (sel_b_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .wdata     (wdata),
    .pwr_active(pwr_active),
    .wake_pulse(wake_pulse)
);

// File: tb/apd_monitor_test.sv
`timescale 1ns/1ps
module apd_monitor_test;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 4;
    localparam int HOLD   = 5;
    localparam int NVEC   = 24;

    typedef struct packed {
        logic              a;
        logic              b;
        logic              w;
        logic [ADDR_W-1:0] ad;
        logic [DATA_W-1:0] d;
        logic              exp_act;
        logic              exp_pls;
        logic [3:0]        req;
    } vec_t;

    // Rows start from an idle, deselected interface after reset.
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b1,1'b1,1'b1,14'd0,4'd0,1'b0,1'b0,4'd9},  // R9 deselected idle
        '{1'b0,1'b1,1'b1,14'd0,4'd0,1'b0,1'b0,4'd6},  // R6 select falls, partner high
        '{1'b0,1'b1,1'b1,14'd5,4'd0,1'b0,1'b0,4'd6},  // R6 address moves while deselected
        '{1'b0,1'b0,1'b1,14'd5,4'd0,1'b1,1'b1,4'd2},  // R2 second select falls
        '{1'b0,1'b0,1'b1,14'd5,4'd0,1'b1,1'b0,4'd7},  // R7 window
        '{1'b0,1'b0,1'b1,14'd5,4'd0,1'b1,1'b0,4'd7},
        '{1'b0,1'b0,1'b1,14'd5,4'd0,1'b1,1'b0,4'd7},
        '{1'b0,1'b0,1'b1,14'd5,4'd0,1'b1,1'b0,4'd7},
        '{1'b0,1'b0,1'b1,14'd5,4'd0,1'b0,1'b0,4'd7},  // R7 expiry after 5
        '{1'b0,1'b0,1'b1,14'd6,4'd0,1'b1,1'b1,4'd4},  // R4 address change
        '{1'b0,1'b0,1'b1,14'd6,4'd3,1'b1,1'b0,4'd5},  // R5 data moves, strobe high
        '{1'b0,1'b0,1'b1,14'd6,4'd3,1'b1,1'b0,4'd5},
        '{1'b0,1'b0,1'b1,14'd6,4'd3,1'b1,1'b0,4'd5},
        '{1'b0,1'b0,1'b1,14'd6,4'd3,1'b1,1'b0,4'd5},
        '{1'b0,1'b0,1'b1,14'd6,4'd3,1'b0,1'b0,4'd5},  // R5 no reload happened
        '{1'b0,1'b0,1'b0,14'd6,4'd3,1'b1,1'b1,4'd3},  // R3 strobe falls
        '{1'b0,1'b0,1'b0,14'd6,4'd1,1'b1,1'b1,4'd5},  // R5 data moves while writing
        '{1'b0,1'b0,1'b0,14'd6,4'd1,1'b1,1'b0,4'd10}, // R10 single pulse
        '{1'b1,1'b0,1'b0,14'd6,4'd1,1'b0,1'b0,4'd9},  // R9 deselect mid-window
        '{1'b0,1'b0,1'b0,14'd6,4'd1,1'b1,1'b1,4'd2},  // R2 first select falls
        '{1'b0,1'b0,1'b1,14'd6,4'd1,1'b1,1'b0,4'd6},  // R6 strobe rising
        '{1'b1,1'b0,1'b1,14'd6,4'd1,1'b0,1'b0,4'd9},  // R9
        '{1'b1,1'b0,1'b0,14'd6,4'd1,1'b0,1'b0,4'd6},  // R6 strobe falls deselected
        '{1'b1,1'b1,1'b0,14'd9,4'd2,1'b0,1'b0,4'd6}   // R6 buses move deselected
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_a_n = 1'b1;
    logic              sel_b_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              pwr_active;
    logic              wake_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    apd_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .pwr_active(pwr_active), .wake_pulse(wake_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic a, input logic b, input logic w,
                         input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] d);
        sel_a_n = a; sel_b_n = b; wr_n = w; addr = ad; wdata = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int hi;
        @(negedge clk);
        step();
        check("R1 reset pwr_active", int'(pwr_active), 0);
        check("R1 reset wake_pulse", int'(wake_pulse), 0);
        rst_n = 1'b1;
        step();
        check("R1 after release pwr_active", int'(pwr_active), 0);

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].a, VEC[i].b, VEC[i].w, VEC[i].ad, VEC[i].d);
            step();
            check($sformatf("R%0d row %0d pwr_active", VEC[i].req, i), int'(pwr_active), int'(VEC[i].exp_act));
            check($sformatf("R%0d row %0d wake_pulse", VEC[i].req, i), int'(wake_pulse), int'(VEC[i].exp_pls));
        end

        // R2: both selects fall together, then R8 reload after 3 cycles.
        drive(1, 1, 1, 14'd0, 4'd0);
        step();
        drive(0, 0, 1, 14'd0, 4'd0);
        step();
        check("R2 joint select fall pulse", int'(wake_pulse), 1);
        step();
        step();
        drive(0, 0, 1, 14'h3FFF, 4'd0);
        step();
        check("R8 reload pulse", int'(wake_pulse), 1);
        hi = 1;
        for (int k = 0; k < 20; k++) begin
            step();
            if (!pwr_active) break;
            hi++;
        end
        check("R8 reloaded window length", hi, HOLD);

        // R7: window length measured from a strobe-fall wake.
        drive(0, 0, 0, 14'h3FFF, 4'd0);
        step();
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            if (!pwr_active) break;
            hi++;
            step();
        end
        check("R7 window length", hi, HOLD);

        // R1: reset in the middle of an active window.
        drive(0, 0, 0, 14'h0101, 4'd0);
        step();
        check("R1 precondition active", int'(pwr_active), 1);
        rst_n = 1'b0;
        step();
        check("R1 mid-window reset", int'(pwr_active), 0);
        drive(1, 1, 1, 14'd0, 4'd0);
        step();
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", int'(pwr_active), 0);

        finish_run();
    end

endmodule